// File: doc/BRIEF.md
# Bit-Serial Ethernet Frame Transmitter

This block sends Ethernet frames one bit per transmit clock over a single-bit serial line. The host streams frame bytes into an internal buffer. The bytes run from the destination address to the last data byte. A valid/ready handshake carries the bytes, and a marker flags the final byte. The block holds off the line until a full collision window of data is buffered, or until the whole frame is buffered if the frame is shorter. It then waits for the medium to be idle, counting an inter-frame gap from the moment carrier sense drops or its own previous frame ends. Once the gap has passed, it raises transmit enable and shifts out a preamble, a start delimiter, the frame body, zero padding up to the minimum body size, and a CRC-32 frame check sequence.

The host sends one frame at a time. After the final byte is accepted, the input stays closed until the frame either completes or is aborted. A collision seen while transmitting cuts the frame within one bit time, raises a one-cycle status pulse and discards everything left of that frame. If the host has not yet delivered the rest of the aborted frame, those bytes are accepted and dropped. The clock input is the transmit bit clock. Carrier sense is the receive-enable line of the serial interface.

Top module: `eth_serial_tx`

## Requirements
- R1: Transmit enable rises only when, two cycles earlier, at least 64 bytes of the current frame had been accepted or its last byte had been accepted.
- R2: Each frame starts with seven 0x55 bytes followed by one 0xD5 byte, every byte sent least significant bit first, so the first bit on tx_d is 1.
- R3: The host's bytes follow the delimiter in the order accepted, each least significant bit first.
- R4: When the host supplies fewer than 60 body bytes, zero bytes are appended until the body is 60 bytes. A frame therefore carries 64 + 8*max(N,60) + 32 bits while transmit enable is high.
- R5: The last 32 bits are the CRC-32 of the body and its padding, low-order byte first and least significant bit first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones and a complemented result.
- R6: Transmit enable rises only after at least 96 consecutive bit times in which both carrier sense and transmit enable were low. This applies after carrier sense drops and also between back-to-back frames.
- R7: When collision is high on a clock edge while transmit enable is high, transmit enable is low after that edge and tx_col is high for exactly that one cycle. No tx_done is raised for that frame.
- R8: After a collision, the remaining bytes of the aborted frame are discarded, and the next frame is sent intact.
- R9: Collision while transmit enable is low has no effect: tx_col stays low.
- R10: tx_done pulses for one cycle, in the first cycle that transmit enable is low after the last check-sequence bit.
- R11: After the last byte of a frame is accepted, s_ready stays low until the frame completes.
- R12: After reset, tx_en, tx_done and tx_col are low and s_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 8 | Host frame byte |
| s_valid | input | 1 | Host byte valid |
| s_last | input | 1 | Marks the final byte of the frame |
| s_ready | output | 1 | Block accepts a byte this cycle |
| crs | input | 1 | Carrier sense (receive enable of the line) |
| col | input | 1 | Collision indication |
| tx_en | output | 1 | Transmit enable |
| tx_d | output | 1 | Serial transmit data |
| tx_done | output | 1 | One-cycle pulse after a frame is fully sent |
| tx_col | output | 1 | One-cycle pulse when a frame is aborted by collision |

## Verification
The bench aims at body lengths around the pad boundary (1, 59, 60, 61) and around the buffering threshold (63, 64, 65). A wrong pad rule shows up as a wrong bit count or a CRC mismatch. A wrong threshold shows up as transmit enable rising before 64 bytes or the last byte had arrived. Carrier-sense bursts at random times and a long forced busy period test the deferral. A gap counter off by a few bits, or one that fails to restart, would let transmit enable rise too soon after the line went quiet. Collisions are injected early in the preamble, while the host is still streaming, and late in the body. The frame that follows each collision is compared bit for bit, so leftover buffered bytes or a missed drop mode would corrupt it.

// File: rtl/eth_serial_tx_pkg.sv
package eth_serial_tx_pkg;

    localparam logic [7:0]  PREAMBLE_BYTE = 8'h55;
    localparam logic [7:0]  DELIM_BYTE    = 8'hD5;
    localparam logic [31:0] CRC_REFL_POLY = 32'hEDB88320;
    localparam int          LEAD_BYTES    = 8;   // preamble plus delimiter
    localparam int          FCS_BITS      = 32;

    typedef enum logic [2:0] {
        SER_IDLE,
        SER_LEAD,
        SER_BODY,
        SER_PAD,
        SER_FCS
    } ser_state_e;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } fifo_word_t;

    // One serial step of the reflected CRC-32
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        crc_step = (c[0] ^ b) ? ((c >> 1) ^ CRC_REFL_POLY) : (c >> 1);
    endfunction

endpackage

// File: rtl/ethtx_fifo.sv
module ethtx_fifo
    import eth_serial_tx_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       flush,
    input  logic                       wr_en,
    input  fifo_word_t                 wr_word,
    input  logic                       rd_en,
    output fifo_word_t                 rd_word,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    fifo_word_t      mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            do_wr;
    logic            do_rd;

    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full && !flush;
    assign do_rd   = rd_en && (count != '0) && !flush;
    assign rd_word = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        bump = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/ethtx_defer.sv
module ethtx_defer #(
    parameter int GAP_BITS = 96
) (
    input  logic clk,
    input  logic rst,
    input  logic crs,
    input  logic busy,
    output logic gap_ok
);
    localparam int GW = $clog2(GAP_BITS + 1);

    logic [GW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst || crs || busy) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != GW'(GAP_BITS)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign gap_ok = (quiet_cnt == GW'(GAP_BITS)) && !crs && !busy;

endmodule

// File: rtl/ethtx_serializer.sv
module ethtx_serializer
    import eth_serial_tx_pkg::*;
#(
    parameter int MIN_BODY = 60,
    parameter int MAX_BODY = 1514
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  fifo_word_t head,
    input  logic       col,
    output logic       pop,
    output logic       abort,
    output logic       busy,
    output logic       tx_en,
    output logic       tx_d,
    output logic       done,
    output logic       col_pulse
);
    localparam int CNT_W = $clog2(MAX_BODY + 1);
    localparam int FW    = $clog2(FCS_BITS);

    ser_state_e       state;
    logic [2:0]       bit_idx;
    logic [CNT_W-1:0] byte_cnt;
    logic [7:0]       lead_byte;
    logic [31:0]      crc;
    logic [FW-1:0]    fcs_idx;
    logic             done_pend;
    logic             cur_bit;
    logic             byte_end;

    assign abort    = col && tx_en;
    assign byte_end = (bit_idx == 3'd7);
    assign pop      = (state == SER_BODY) && byte_end && !abort;
    assign busy     = (state != SER_IDLE) || tx_en;

    always_comb begin
        case (state)
            SER_LEAD: cur_bit = lead_byte[bit_idx];
            SER_BODY: cur_bit = head.data[bit_idx];
            SER_FCS:  cur_bit = ~crc[0];
            default:  cur_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SER_IDLE;
            bit_idx   <= '0;
            byte_cnt  <= '0;
            lead_byte <= PREAMBLE_BYTE;
            crc       <= '1;
            fcs_idx   <= '0;
            done_pend <= 1'b0;
            tx_en     <= 1'b0;
            tx_d      <= 1'b0;
            done      <= 1'b0;
            col_pulse <= 1'b0;
        end else if (abort) begin
            state     <= SER_IDLE;
            tx_en     <= 1'b0;
            tx_d      <= 1'b0;
            done_pend <= 1'b0;
            done      <= 1'b0;
            col_pulse <= 1'b1;
        end else begin
            done      <= done_pend;
            done_pend <= 1'b0;
            col_pulse <= 1'b0;
            case (state)
                SER_IDLE: begin
                    tx_en <= 1'b0;
                    tx_d  <= 1'b0;
                    if (start) begin
                        state     <= SER_LEAD;
                        bit_idx   <= '0;
                        byte_cnt  <= '0;
                        lead_byte <= PREAMBLE_BYTE;
                        crc       <= '1;
                    end
                end
                SER_LEAD: begin
                    tx_en   <= 1'b1;
                    tx_d    <= cur_bit;
                    bit_idx <= bit_idx + 1'b1;
                    if (byte_end) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == CNT_W'(LEAD_BYTES - 2)) lead_byte <= DELIM_BYTE;
                        if (byte_cnt == CNT_W'(LEAD_BYTES - 1)) begin
                            state    <= SER_BODY;
                            byte_cnt <= '0;
                        end
                    end
                end
                SER_BODY: begin
                    tx_en   <= 1'b1;
                    tx_d    <= cur_bit;
                    crc     <= crc_step(crc, cur_bit);
                    bit_idx <= bit_idx + 1'b1;
                    if (byte_end) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (head.last) begin
                            fcs_idx <= '0;
                            state   <= (byte_cnt < CNT_W'(MIN_BODY - 1)) ? SER_PAD : SER_FCS;
                        end
                    end
                end
                SER_PAD: begin
                    tx_en   <= 1'b1;
                    tx_d    <= 1'b0;
                    crc     <= crc_step(crc, 1'b0);
                    bit_idx <= bit_idx + 1'b1;
                    if (byte_end) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (byte_cnt == CNT_W'(MIN_BODY - 1)) state <= SER_FCS;
                    end
                end
                SER_FCS: begin
                    tx_en   <= 1'b1;
                    tx_d    <= cur_bit;
                    crc     <= crc >> 1;
                    fcs_idx <= fcs_idx + 1'b1;
                    if (fcs_idx == FW'(FCS_BITS - 1)) begin
                        state     <= SER_IDLE;
                        done_pend <= 1'b1;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eth_serial_tx.sv
module eth_serial_tx
    import eth_serial_tx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 128,
    parameter int WINDOW_BITS = 512,
    parameter int IFG_BITS    = 96,
    parameter int MIN_BODY    = 60,
    parameter int MAX_BODY    = 1514
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] s_data,
    input  logic       s_valid,
    input  logic       s_last,
    output logic       s_ready,
    input  logic       crs,
    input  logic       col,
    output logic       tx_en,
    output logic       tx_d,
    output logic       tx_done,
    output logic       tx_col
);
    localparam int THRESH_BYTES = WINDOW_BITS / 8;
    localparam int CW           = $clog2(FIFO_DEPTH + 1);

    logic          frame_closed;
    logic          dropping;
    logic          accept;
    logic          wr_en;
    logic          fifo_full;
    logic [CW-1:0] fifo_count;
    fifo_word_t    head;
    fifo_word_t    in_word;
    logic          pop;
    logic          abort;
    logic          busy;
    logic          gap_ok;
    logic          frame_ready;
    logic          start;

    assign s_ready     = dropping || (!frame_closed && !fifo_full);
    assign accept      = s_valid && s_ready;
    assign wr_en       = accept && !dropping;
    assign in_word     = '{last: s_last, data: s_data};
    assign frame_ready = frame_closed ? (fifo_count != '0)
                                      : (fifo_count >= CW'(THRESH_BYTES));
    assign start       = frame_ready && gap_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_closed <= 1'b0;
            dropping     <= 1'b0;
        end else if (abort) begin
            frame_closed <= 1'b0;
            dropping     <= !frame_closed && !(accept && s_last);
        end else begin
            if (dropping && accept && s_last) dropping <= 1'b0;
            if (wr_en && s_last)              frame_closed <= 1'b1;
            else if (tx_done)                 frame_closed <= 1'b0;
        end
    end

    ethtx_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk     (clk),
        .rst     (rst),
        .flush   (abort),
        .wr_en   (wr_en),
        .wr_word (in_word),
        .rd_en   (pop),
        .rd_word (head),
        .count   (fifo_count),
        .full    (fifo_full)
    );

    ethtx_defer #(
        .GAP_BITS (IFG_BITS)
    ) defer_i (
        .clk    (clk),
        .rst    (rst),
        .crs    (crs),
        .busy   (busy),
        .gap_ok (gap_ok)
    );

    ethtx_serializer #(
        .MIN_BODY (MIN_BODY),
        .MAX_BODY (MAX_BODY)
    ) ser_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .head      (head),
        .col       (col),
        .pop       (pop),
        .abort     (abort),
        .busy      (busy),
        .tx_en     (tx_en),
        .tx_d      (tx_d),
        .done      (tx_done),
        .col_pulse (tx_col)
    );

endmodule

// File: rtl/eth_serial_tx_chk.sv
module eth_serial_tx_chk #(
    parameter int IFG_BITS   = 96,
    parameter int FIFO_DEPTH = 128
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            crs,
    input logic                            col,
    input logic                            tx_en,
    input logic                            tx_d,
    input logic                            tx_done,
    input logic                            tx_col,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_count
);
    localparam int QW = $clog2(IFG_BITS + 4);

    logic [QW-1:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (rst || crs || tx_en) quiet_cnt <= '0;
        else if (quiet_cnt != QW'(IFG_BITS + 2)) quiet_cnt <= quiet_cnt + 1'b1;
    end

    AST_GAP_BEFORE_TX: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> ($past(quiet_cnt) >= QW'(IFG_BITS))); // R6
    AST_PRE_FIRST_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |-> tx_d); // R2
    AST_COL_CUTS_TX: assert property (@(posedge clk) disable iff (rst)
        (tx_en && col) |=> (!tx_en && tx_col)); // R7
    AST_COL_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        tx_col |=> !tx_col); // R7
    AST_DONE_NOT_COL: assert property (@(posedge clk) disable iff (rst)
        !(tx_done && tx_col)); // R7
    AST_IDLE_COL_QUIET: assert property (@(posedge clk) disable iff (rst)
        tx_col |-> $past(tx_en && col)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (!tx_en && $past(tx_en))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)); // R1

endmodule

bind eth_serial_tx eth_serial_tx_chk #(
    .IFG_BITS   (IFG_BITS),
    .FIFO_DEPTH (FIFO_DEPTH)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .crs        (crs),
    .col        (col),
    .tx_en      (tx_en),
    .tx_d       (tx_d),
    .tx_done    (tx_done),
    .tx_col     (tx_col),
    .fifo_count (fifo_count)
);

// File: tb/eth_serial_tx_tb_top.sv
module eth_serial_tx_tb_top;

    localparam int THRESH = 64;
    localparam int GAP    = 96;
    localparam int MINB   = 60;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] s_data = '0;
    logic       s_valid = 1'b0;
    logic       s_last = 1'b0;
    logic       s_ready;
    logic       crs = 1'b0;
    logic       col;
    logic       col_idle = 1'b0;
    logic       col_inj = 1'b0;
    logic       tx_en, tx_d, tx_done, tx_col;

    always #5 clk = ~clk;
    assign col = col_idle | col_inj;

    eth_serial_tx dut_i (
        .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
        .s_ready(s_ready), .crs(crs), .col(col), .tx_en(tx_en), .tx_d(tx_d),
        .tx_done(tx_done), .tx_col(tx_col)
    );

    int checks = 0;
    int fails  = 0;
    int frames_done = 0;
    int col_delay = 0;
    int crs_mode = 0;
    bit after_abort = 0;

    bq_t exp_q;
    int  len_q[$];
    bit  abort_q[$];
    bit  bits_q[$];
    bit  eb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input bq_t d);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (d[i]) begin
            c = c ^ {24'h0, d[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic int first_mism(input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            if (i >= bits_q.size() || i >= eb.size()) return i;
            if (bits_q[i] != eb[i]) return i;
        end
        return -1;
    endfunction

    task automatic push_bits(input logic [7:0] b);
        for (int k = 0; k < 8; k++) eb.push_back(b[k]);
    endtask

    task automatic process_frame();
        int L; bit ab; bq_t fr; logic [31:0] f; int tot; int m;
        L = len_q.pop_front();
        ab = abort_q.pop_front();
        fr = {};
        for (int i = 0; i < L; i++) fr.push_back(exp_q.pop_front());
        if (ab) begin
            check(tx_col === 1'b1, "R7", "collision pulse at abort", tx_col, 1);
            check(tx_done === 1'b0, "R7", "no done on aborted frame", tx_done, 0);
            after_abort = 1;
        end else begin
            while (fr.size() < MINB) fr.push_back(8'h00);
            f = ref_crc(fr);
            eb.delete();
            for (int i = 0; i < 7; i++) push_bits(8'h55);
            push_bits(8'hD5);
            foreach (fr[i]) push_bits(fr[i]);
            for (int i = 0; i < 4; i++) push_bits(f[8*i +: 8]);
            tot = eb.size();
            check(bits_q.size() == tot, "R4", "frame bit count", bits_q.size(), tot);
            m = first_mism(0, 64);
            check(m < 0, "R2", "preamble/delimiter first bad bit", m, -1);
            m = first_mism(64, 64 + 8 * L);
            if (after_abort) check(m < 0, "R8", "frame after collision body bad bit", m, -1);
            else             check(m < 0, "R3", "body first bad bit", m, -1);
            if (L < MINB) begin
                m = first_mism(64 + 8 * L, 64 + 8 * MINB);
                check(m < 0, "R4", "pad first bad bit", m, -1);
            end
            m = first_mism(tot - 32, tot);
            check(m < 0, "R5", "check sequence first bad bit", m, -1);
            check(tx_done === 1'b1, "R10", "done at end of frame", tx_done, 1);
            check(tx_col === 1'b0, "R10", "no collision flag on good frame", tx_col, 0);
            after_abort = 0;
        end
        bits_q.delete();
        frames_done++;
    endtask

    // acceptance tracking at the clock edge
    int acc_cnt = 0;
    bit acc_last = 0;
    bit new_frame = 1;
    always @(posedge clk) begin
        if (!rst && s_valid && s_ready) begin
            acc_cnt  <= new_frame ? 1 : acc_cnt + 1;
            acc_last <= s_last;
            new_frame <= s_last;
        end
    end

    // monitor, away from the active edge
    bit prev_en = 0, prev_done = 0, prev_col = 0;
    int quiet = 0, q_h1 = 0, q_h2 = 0, a_h1 = 0, a_h2 = 0;
    bit l_h1 = 0, l_h2 = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!crs && !tx_en) quiet++; else quiet = 0;
            if (tx_en && !prev_en) begin
                check(a_h2 >= THRESH || l_h2, "R1", "bytes buffered before start", a_h2, THRESH);
                check(q_h2 >= GAP, "R6", "quiet bit times before start", q_h2, GAP);
            end
            if (tx_en) bits_q.push_back(tx_d);
            if (!tx_en && prev_en) process_frame();
            if (tx_done && prev_done) check(0, "R10", "done wider than one cycle", 2, 1);
            if (tx_col && prev_col) check(0, "R7", "collision pulse wider than one cycle", 2, 1);
            prev_en = tx_en; prev_done = tx_done; prev_col = tx_col;
            q_h2 = q_h1; q_h1 = quiet;
            a_h2 = a_h1; a_h1 = acc_cnt;
            l_h2 = l_h1; l_h1 = acc_last;
        end
    end

    // carrier sense generator
    int crs_timer = 0;
    always @(negedge clk) begin
        case (crs_mode)
            1: begin
                if (crs_timer == 0) begin
                    crs = ~crs;
                    crs_timer = crs ? int'($urandom_range(150, 5)) : int'($urandom_range(400, 50));
                end else crs_timer--;
            end
            2:       crs = 1'b1;
            default: crs = 1'b0;
        endcase
    end

    // collision injection relative to the start of a frame
    initial begin
        forever begin
            @(posedge tx_en);
            if (col_delay > 0) begin
                int d;
                d = col_delay;
                col_delay = 0;
                repeat (d) @(negedge clk);
                col_inj = 1'b1;
                @(negedge clk);
                col_inj = 1'b0;
            end
        end
    end

    task automatic push_byte(input logic [7:0] b, input logic l);
        @(negedge clk);
        s_valid = 1'b1; s_data = b; s_last = l;
        while (!s_ready) @(negedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic send_frame(input int len, input int maxgap, input int cdel);
        logic [7:0] b[$];
        int target;
        for (int i = 0; i < len; i++) begin
            b.push_back(8'($urandom));
            exp_q.push_back(b[i]);
        end
        len_q.push_back(len);
        abort_q.push_back(cdel != 0);
        col_delay = cdel;
        target = frames_done + 1;
        for (int i = 0; i < len; i++) begin
            push_byte(b[i], i == len - 1);
            if (i == len - 1 && cdel == 0)
                check(s_ready === 1'b0, "R11", "ready low after last byte", s_ready, 0);
            repeat ($urandom_range(maxgap, 0)) @(negedge clk);
        end
        while (frames_done < target) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
        finish_up();
    end

    initial begin
        bq_t t;
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_en === 1'b0, "R12", "tx_en after reset", tx_en, 0);
        check(tx_done === 1'b0, "R12", "tx_done after reset", tx_done, 0);
        check(tx_col === 1'b0, "R12", "tx_col after reset", tx_col, 0);
        check(s_ready === 1'b1, "R12", "s_ready after reset", s_ready, 1);

        t = {8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        check(ref_crc(t) == 32'hCBF43926, "R5", "bench crc self test", ref_crc(t), 32'hCBF43926);

        // pad and threshold boundaries
        send_frame(1, 0, 0);
        send_frame(14, 3, 0);
        send_frame(59, 5, 0);
        send_frame(60, 0, 0);
        send_frame(61, 2, 0);
        send_frame(63, 5, 0);
        send_frame(64, 5, 0);
        send_frame(65, 4, 0);
        send_frame(200, 0, 0);

        // collision while idle is ignored
        repeat (20) @(negedge clk);
        col_idle = 1'b1;
        @(negedge clk);
        col_idle = 1'b0;
        check(tx_col === 1'b0, "R9", "no collision flag while idle", tx_col, 0);
        check(tx_en === 1'b0, "R9", "still idle after idle collision", tx_en, 0);

        // long busy medium while a frame waits
        crs_mode = 2;
        fork
            begin repeat (400) @(negedge clk); crs_mode = 0; end
            send_frame(80, 2, 0);
        join

        // collisions early (host still streaming) and late
        send_frame(120, 1, 30);
        send_frame(100, 0, 0);
        send_frame(150, 2, 300);
        send_frame(70, 0, 0);

        // random traffic with random carrier activity
        crs_mode = 1;
        for (int n = 0; n < 12; n++) send_frame(int'($urandom_range(160, 1)), int'($urandom_range(5, 0)), 0);
        crs_mode = 0;

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all expected bytes consumed", exp_q.size(), 0);
        finish_up();
    end

endmodule